// File: doc/BRIEF.md
# Parallel Memory Write Strobe Qualifier

This block sits on the device side of an asynchronous parallel memory port, ahead of the storage array. It samples three active-low control lines: chip select, write strobe and read enable. Each line passes through a two-flop synchronizer and a minimum-width filter. The block then turns the overlap of chip select and write strobe into one clean internal write event. The event carries the address that was present when the overlap began and the data byte that was present when it ended. This works the same way whether chip select or the write strobe is the line that toggles.

Writes are refused in several cases. They are refused while the supply-good input is low and during a programmable lockout after that input rises. They are refused whenever chip select or the write strobe is high, and whenever the read enable is low. The block also produces the enable for the data-bus output drivers, so that reads do not fight the host on the bus.

Top module: `strobe_write_qualifier`

## Requirements
- R1: A write is accepted only while chip select and write strobe are both low and read enable is high. A cycle in which read enable is held low, or chip select is held high while the write strobe pulses, produces no pulse.
- R2: `wr_addr` carries the value of `addr_in` at the start of the qualified overlap, which is set by whichever of the two strobes falls last. Address changes later in the same overlap have no effect.
- R3: `wr_data` carries the value of `data_in` at the end of the overlap, which is set by whichever of the two strobes rises first.
- R4: A cycle controlled by the write strobe (chip select low first) and a cycle controlled by chip select (write strobe low first) are both accepted.
- R5: A synchronized low pulse on the write strobe or chip select that lasts fewer than `GLITCH_CYC` clock cycles starts no write. A pulse of exactly `GLITCH_CYC` cycles does start one.
- R6: No write is accepted whose overlap begins within `POR_CYC` clock cycles after `supply_ok` rises or after reset is released with `supply_ok` high.
- R7: While `supply_ok` is low, no write is accepted. A drop of `supply_ok` during an overlap cancels that write.
- R8: `bus_drive` is 1 exactly when `oe_n` and `ce_n` are both low, and 0 otherwise.
- R9: Each accepted write gives `wr_pulse` high for exactly one cycle. `wr_addr` and `wr_data` change only in that cycle and hold their values otherwise.
- R10: If read enable goes low during an overlap, that write is cancelled.
- R11: After reset, `wr_pulse`, `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Digital supply-good indication |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Read enable, active low, asynchronous |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Write data bus |
| wr_pulse | output | 1 | One-cycle write-accepted pulse |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| bus_drive | output | 1 | Data-bus output driver enable |

## Verification
The assertions check on every cycle the following properties:
- the write pulse is one cycle wide and the captured address and data hold between pulses;
- a pulse never follows a cycle with the supply low;
- no pulse appears before the lockout window has elapsed.

Other behaviour can only be shown by the bench's scenarios, because each one depends on a whole sequence of strobe edges. These are:
- which edge supplies the address and which supplies the data;
- the width boundary of the glitch filter;
- the cancellation of a write when the read enable falls mid-overlap;
- both styles of write cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int STB_CE = 0;
  localparam int STB_WE = 1;
  localparam int STB_OE = 2;
  localparam int N_STB  = 3;

  typedef enum logic {
    CAP_IDLE  = 1'b0,
    CAP_ARMED = 1'b1
  } cap_state_e;
endpackage

// File: rtl/sq_sync_filter.sv
module sq_sync_filter #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic          s1_q, s2_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (s2_q != filt_q) begin
      if (cnt_q == CW'(GLITCH_CYC - 1)) begin
        filt_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/sq_por_lockout.sv
module sq_por_lockout #(
  parameter int POR_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic wr_enable
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done = (cnt_q == LIMIT);

  always_comb begin
    if (!supply_ok)  cnt_d = '0;
    else if (done)   cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wr_enable = supply_ok && done;
endmodule

// File: rtl/sq_write_capture.sv
module sq_write_capture
  import sq_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          oe_f,
  input  logic          wr_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  cap_state_e    st_q, st_d;
  logic          ovl, ovl_q, ovl_start;
  logic [AW-1:0] lat_q, lat_d;
  logic          pulse_d, pulse_q;
  logic          out_en;
  logic [AW-1:0] oaddr_q;
  logic [DW-1:0] odata_q;

  assign ovl       = !ce_f && !we_f && oe_f;
  assign ovl_start = ovl && !ovl_q;

  always_comb begin
    st_d    = st_q;
    lat_d   = lat_q;
    pulse_d = 1'b0;
    out_en  = 1'b0;
    case (st_q)
      CAP_IDLE: begin
        if (ovl_start && wr_en) begin
          st_d  = CAP_ARMED;
          lat_d = addr_in;
        end
      end
      CAP_ARMED: begin
        if (!wr_en || !oe_f) begin
          st_d = CAP_IDLE;
        end else if (ce_f || we_f) begin
          st_d    = CAP_IDLE;
          pulse_d = 1'b1;
          out_en  = 1'b1;
        end
      end
      default: st_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CAP_IDLE;
      ovl_q   <= 1'b0;
      lat_q   <= '0;
      pulse_q <= 1'b0;
      oaddr_q <= '0;
      odata_q <= '0;
    end else begin
      st_q    <= st_d;
      ovl_q   <= ovl;
      lat_q   <= lat_d;
      pulse_q <= pulse_d;
      if (out_en) begin
        oaddr_q <= lat_q;
        odata_q <= data_in;
      end
    end
  end

  assign wr_pulse = pulse_q;
  assign wr_addr  = oaddr_q;
  assign wr_data  = odata_q;
endmodule

// File: rtl/strobe_write_qualifier.sv
module strobe_write_qualifier
  import sq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int GLITCH_CYC = 4,
  parameter int POR_CYC    = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          bus_drive
);
  logic [N_STB-1:0] raw_vec, filt_vec;
  logic             wr_en;

  always_comb begin
    raw_vec         = '1;
    raw_vec[STB_CE] = ce_n;
    raw_vec[STB_WE] = we_n;
    raw_vec[STB_OE] = oe_n;
  end

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    sq_sync_filter #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_vec[g]),
      .filt (filt_vec[g])
    );
  end

  sq_por_lockout #(.POR_CYC(POR_CYC)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .wr_enable(wr_en)
  );

  sq_write_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_f    (filt_vec[STB_CE]),
    .we_f    (filt_vec[STB_WE]),
    .oe_f    (filt_vec[STB_OE]),
    .wr_en   (wr_en),
    .addr_in (addr_in),
    .data_in (data_in),
    .wr_pulse(wr_pulse),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign bus_drive = !oe_n && !ce_n;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int POR_CYC = 250000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          wr_pulse,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(POR_CYC + 1);
  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       up_cnt <= '0;
    else if (!supply_ok)              up_cnt <= '0;
    else if (up_cnt != CW'(POR_CYC))  up_cnt <= up_cnt + 1'b1;
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data)));

  p_supply_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(supply_ok));

  p_por_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (up_cnt == CW'(POR_CYC)));
endmodule

bind strobe_write_qualifier sq_checker #(.AW(AW), .DW(DW), .POR_CYC(POR_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_ok(supply_ok),
  .wr_pulse (wr_pulse),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/strobe_write_qualifier_tb.sv
module strobe_write_qualifier_tb;
  localparam int CLK_P = 10;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int GC = 4;
  localparam int PC = 40;

  logic clk, rst_n, supply_ok, ce_n, we_n, oe_n;
  logic [AW-1:0] addr_in, wr_addr;
  logic [DW-1:0] data_in, wr_data;
  logic wr_pulse, bus_drive;

  int checks = 0, failures = 0, npulse = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;
  bit done = 0;

  strobe_write_qualifier #(.AW(AW), .DW(DW), .GLITCH_CYC(GC), .POR_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr_in(addr_in), .data_in(data_in), .wr_pulse(wr_pulse),
    .wr_addr(wr_addr), .wr_data(wr_data), .bus_drive(bus_drive));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (rst_n && wr_pulse) begin
    npulse++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  // mode: 0 write-strobe controlled, 1 chip-select controlled, 2 read enable low, 3 chip select high
  typedef struct packed {
    logic [1:0]    mode;
    logic [7:0]    len;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ex;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 8'd16, 12'h123, 8'h5A, 1'b1},
    '{2'd1, 8'd16, 12'h3C4, 8'hA5, 1'b1},
    '{2'd0, 8'd3,  12'h111, 8'h11, 1'b0},
    '{2'd1, 8'd3,  12'h222, 8'h22, 1'b0},
    '{2'd0, 8'd4,  12'h7FF, 8'h00, 1'b1},
    '{2'd2, 8'd16, 12'h444, 8'h44, 1'b0},
    '{2'd3, 8'd16, 12'h555, 8'h55, 1'b0},
    '{2'd1, 8'd20, 12'hFFF, 8'hFF, 1'b1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] mode, input int len,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr_in = a; data_in = ~d;
    case (mode)
      2'd0: begin ce_n = 1'b0; cyc(3); we_n = 1'b0; end
      2'd1: begin we_n = 1'b0; cyc(3); ce_n = 1'b0; end
      2'd2: begin oe_n = 1'b0; ce_n = 1'b0; cyc(3); we_n = 1'b0; end
      default: begin cyc(3); we_n = 1'b0; end
    endcase
    if (len >= 14) begin
      cyc(10); addr_in = ~a; cyc(len - 10);
    end else begin
      cyc(len);
    end
    data_in = d;
    if (mode == 2'd1) ce_n = 1'b1; else we_n = 1'b1;
    cyc(12);
    data_in = ~d; addr_in = ~a;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    cyc(12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; supply_ok = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr_in = '0; data_in = '0;
    cyc(5);
    rst_n = 1'b1;
    // R11 reset state
    check(wr_pulse == 1'b0 && wr_addr == '0 && wr_data == '0, "R11 reset outputs",
          int'(wr_addr), 0);
    check(bus_drive == 1'b0, "R8 idle no drive", int'(bus_drive), 0);

    // R6 write inside lockout after reset
    p0 = npulse;
    do_write(2'd0, 16, 12'h0AA, 8'hAA);
    check(npulse == p0, "R6 locked after reset", npulse - p0, 0);
    cyc(PC + 10);

    // table walk
    foreach (VEC[i]) begin
      string tag;
      logic [AW-1:0] pa;
      pa = wr_addr;
      p0 = npulse;
      do_write(VEC[i].mode, int'(VEC[i].len), VEC[i].a, VEC[i].d);
      tag = (VEC[i].mode >= 2) ? "R1 inhibit" : (!VEC[i].ex ? "R5 glitch" : "R4 write");
      check(npulse - p0 == int'(VEC[i].ex), tag, npulse - p0, int'(VEC[i].ex));
      if (VEC[i].ex) begin
        check(last_a == VEC[i].a, "R2 address", int'(last_a), int'(VEC[i].a));
        check(last_d == VEC[i].d, "R3 data", int'(last_d), int'(VEC[i].d));
      end else begin
        check(wr_addr == pa, "R9 hold addr", int'(wr_addr), int'(pa));
      end
    end

    // R8 bus drive
    oe_n = 1'b0; ce_n = 1'b0; #1;
    check(bus_drive == 1'b1, "R8 drive on", int'(bus_drive), 1);
    ce_n = 1'b1; #1;
    check(bus_drive == 1'b0, "R8 ce high", int'(bus_drive), 0);
    oe_n = 1'b1; ce_n = 1'b0; #1;
    check(bus_drive == 1'b0, "R8 oe high", int'(bus_drive), 0);
    ce_n = 1'b1;
    cyc(10);

    // R7 supply low
    supply_ok = 1'b0; cyc(2);
    p0 = npulse;
    do_write(2'd0, 16, 12'h0B1, 8'hB1);
    check(npulse == p0, "R7 supply low", npulse - p0, 0);
    supply_ok = 1'b1;
    p0 = npulse;
    do_write(2'd0, 16, 12'h0B2, 8'hB2);
    check(npulse == p0, "R6 locked after supply rise", npulse - p0, 0);
    cyc(PC + 10);
    p0 = npulse;
    do_write(2'd1, 16, 12'h0B3, 8'hB3);
    check(npulse - p0 == 1 && last_a == 12'h0B3, "R6 after lockout", npulse - p0, 1);

    // R7 supply drop during overlap
    p0 = npulse;
    ce_n = 1'b0; cyc(3); we_n = 1'b0; cyc(14);
    supply_ok = 1'b0; cyc(2);
    we_n = 1'b1; cyc(12); ce_n = 1'b1; cyc(4);
    check(npulse == p0, "R7 drop mid write", npulse - p0, 0);
    supply_ok = 1'b1; cyc(PC + 10);

    // R10 read enable falls mid overlap
    p0 = npulse;
    ce_n = 1'b0; cyc(3); we_n = 1'b0; cyc(14);
    oe_n = 1'b0; cyc(10);
    we_n = 1'b1; ce_n = 1'b1; cyc(10);
    oe_n = 1'b1; cyc(12);
    check(npulse == p0, "R10 oe abort", npulse - p0, 0);
    check(wr_addr == 12'h0B3, "R9 hold after abort", int'(wr_addr), 'h0B3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule